// File: doc/BRIEF.md
# Double-Register Load-Multiple Sequencer

This block executes one load-multiple instruction that fills a run of consecutive 64-bit floating-point registers from memory. A one-cycle start strobe presents a 32-bit instruction word, the value of the general-purpose base register and an endianness flag. The block decodes and validates the word. For a legal word it works out the start address and issues 32-bit reads one at a time on a simple request/valid port. It joins each pair of returned words into one 64-bit register value and writes it to the register file through a write strobe with an index.

When the word asks for base update, the block presents the new base value on a writeback strobe after the last register write. Each instruction ends with a single-cycle done pulse. That pulse carries one of three outcome flags, or none: the word belongs to another instruction, the word is undefined, or the field combination has no defined result. Condition evaluation, enable checks and the register file itself are outside the block.

Top module: `dreg_load_seq`

## Requirements
- R1: The word is handled only if bits 27:25 are 110, bit 20 is 1, bits 11:10 are 10 and bits 9:8 are 11, and the mode bits {bit24, bit23, bit21} are neither 000 nor 1x0. Any other word ends with done and the not-handled flag, and causes no reads, register writes or writeback.
- R2: A handled word whose mode bits are 001 or 111 ends with done and the undefined flag only, and causes no traffic. The not-handled check takes priority over this one, and both take priority over the unpredictable check.
- R3: The register count is bits 7:1 of the word. The first register index is {bit22, bits15:12}. Registers are written in ascending index order, one index per register.
- R4: With bit 23 set, the first read address is the base value. With bit 23 clear, it is the base value minus bits 7:0 times 4.
- R5: Each register takes a read at the current address and then a read at that address plus 4. The next register starts 8 bytes above the previous one.
- R6: With the big-endian flag set, the register value is {first word, second word}. With the flag clear, it is {second word, first word}. The flag is sampled at start.
- R7: With bit 21 set, a writeback strobe follows the last register write. It carries index bits 19:16 and the value base plus (bit 23 set) or minus (bit 23 clear) bits 7:0 times 4. Done follows in the next cycle.
- R8: At most one read is outstanding. mem_req is a one-cycle pulse, and the next request is issued only after the valid response. A register write strobe comes in the cycle after the second word's valid.
- R9: The word is flagged unpredictable when any of these holds: the count exceeds 16; the first index plus the count exceeds 32; bit 0 is 1 and the first index plus the count exceeds 16; or the base index is 15 with bit 21 set. Such a word ends with done and the unpredictable flag, and causes no reads, writes or writeback.
- R10: A count of zero with no R9 cause is flagged unpredictable and causes no reads or register writes. It still performs the R7 writeback when bit 21 is set.
- R11: done is a one-cycle pulse per accepted start. The outcome flags are high only together with done. All outputs are low after reset.
- R12: A start strobe that arrives while an instruction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Base register value |
| big_endian | input | 1 | Word order for register assembly |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 5 | Register index to write |
| rf_data | output | 64 | Register value |
| wb_we | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Base register index |
| wb_val | output | 32 | New base value |
| done | output | 1 | End-of-instruction pulse |
| undef_flag | output | 1 | Undefined encoding |
| unhandled_flag | output | 1 | Word belongs to another instruction |
| unpred_flag | output | 1 | Field combination without defined result |

## Verification
The assertions check the handshake rules on every cycle. They cover the single-pulse requests, register writes only after a valid response, done pulses that last one cycle, flags that appear only with done (and only one at a time), and writeback directly ahead of done. The bench's scenarios cover what depends on values. Address order in both directions, word order under each endianness, the count and index arithmetic at 16 registers and at the index limits, the decode priority, zero-count writeback and a start pulse ignored mid-transfer can only be shown there, by comparing every strobe against a scoreboard.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  localparam int WORD_W = 32;
  localparam int DREG_W = 2 * WORD_W;
  localparam int IDX_W  = 5;
  localparam int GPR_W  = 4;
  localparam int CNT_W  = 8;
  localparam int IMM_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RQ_LO,
    ST_WT_LO,
    ST_RQ_HI,
    ST_WT_HI,
    ST_WRITE,
    ST_WB,
    ST_FIN
  } seq_state_t;

  typedef struct packed {
    logic              unhandled;
    logic              undef;
    logic              unpred;
    logic              nop_wb;
    logic              up;
    logic              wback;
    logic [IDX_W-1:0]  first;
    logic [GPR_W-1:0]  rn;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] offset;
  } dec_t;

  // Byte span of the list: immediate times four, zero-extended.
  function automatic logic [WORD_W-1:0] f_offset(input logic [IMM_W-1:0] imm);
    return {{(WORD_W-IMM_W-2){1'b0}}, imm, 2'b00};
  endfunction

  // Register count: immediate halved, rounded down.
  function automatic logic [CNT_W-1:0] f_count(input logic [IMM_W-1:0] imm);
    return {1'b0, imm[IMM_W-1:1]};
  endfunction

  function automatic logic [WORD_W-1:0] f_first_addr(input logic [WORD_W-1:0] base,
                                                     input logic [WORD_W-1:0] off,
                                                     input logic up);
    return up ? base : base - off;
  endfunction

  function automatic logic [WORD_W-1:0] f_wb_value(input logic [WORD_W-1:0] base,
                                                   input logic [WORD_W-1:0] off,
                                                   input logic up);
    return up ? base + off : base - off;
  endfunction

endpackage

// File: rtl/dbl_decode.sv
module dbl_decode
  import dbl_pkg::*;
#(
  parameter int MAX_LIST  = 16,
  parameter int NUM_DREGS = 32,
  parameter int PC_IDX    = 15
) (
  input  logic [31:0] instr,
  output dec_t        dec
);

  localparam int SPAN_W = IDX_W + CNT_W;

  logic       cls_ok, other_instr, valid, fault, zero;
  logic [2:0] mode;
  logic [SPAN_W-1:0] span;
  logic [3:0] unused_cond;

  assign unused_cond = instr[31:28];

  assign cls_ok = (instr[27:25] == 3'b110) && instr[20] &&
                  (instr[11:10] == 2'b10) && (instr[9:8] == 2'b11);
  assign mode   = {instr[24], instr[23], instr[21]};

  // 000 and 1x0 are other instructions sharing this space.
  assign other_instr = (mode == 3'b000) || (mode[2] && !mode[0]);

  always_comb begin
    dec           = '0;
    dec.first     = {instr[22], instr[15:12]};
    dec.rn        = instr[19:16];
    dec.count     = f_count(instr[7:0]);
    dec.offset    = f_offset(instr[7:0]);
    dec.up        = instr[23];
    dec.wback     = instr[21];
    dec.unhandled = !cls_ok || other_instr;
    dec.undef     = !dec.unhandled && (mode[2] == mode[1]) && mode[0];
    dec.unpred    = valid && (zero || fault);
    dec.nop_wb    = valid && zero && !fault && instr[21];
  end

  assign valid = !dec.unhandled && !dec.undef;
  assign span  = SPAN_W'(dec.first) + SPAN_W'(dec.count);
  assign zero  = (dec.count == '0);
  assign fault = (dec.count > CNT_W'(MAX_LIST)) ||
                 (span > SPAN_W'(NUM_DREGS)) ||
                 (instr[0] && (span > SPAN_W'(MAX_LIST))) ||
                 ((dec.rn == GPR_W'(PC_IDX)) && dec.wback);

endmodule

// File: rtl/dbl_pair.sv
module dbl_pair #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]   word_a,
  input  logic [WORD_W-1:0]   word_b,
  input  logic                big,
  output logic [2*WORD_W-1:0] value
);

  // word_a came from the lower address.
  assign value = big ? {word_a, word_b} : {word_b, word_a};

endmodule

// File: rtl/dreg_load_seq.sv
module dreg_load_seq
  import dbl_pkg::*;
#(
  parameter int MAX_LIST  = 16,
  parameter int NUM_DREGS = 32,
  parameter int PC_IDX    = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] instr,
  input  logic [31:0] base_val,
  input  logic        big_endian,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_valid,
  input  logic [31:0] mem_rdata,
  output logic        rf_we,
  output logic [4:0]  rf_idx,
  output logic [63:0] rf_data,
  output logic        wb_we,
  output logic [3:0]  wb_idx,
  output logic [31:0] wb_val,
  output logic        done,
  output logic        undef_flag,
  output logic        unhandled_flag,
  output logic        unpred_flag
);

  localparam int WORD_BYTES = WORD_W / 8;

  dec_t              dec;
  seq_state_t        state;
  logic [WORD_W-1:0] addr_r, wb_val_r, word_a_r, word_b_r;
  logic [GPR_W-1:0]  wb_idx_r;
  logic [CNT_W-1:0]  left_r;
  logic [IDX_W-1:0]  idx_r;
  logic              be_r, wback_r;
  logic [2:0]        flags_r;

  // Named internal events.
  logic ev_accept, ev_word_lo, ev_word_hi, ev_last_write;

  dbl_decode #(
    .MAX_LIST (MAX_LIST),
    .NUM_DREGS(NUM_DREGS),
    .PC_IDX   (PC_IDX)
  ) u_decode (
    .instr(instr),
    .dec  (dec)
  );

  dbl_pair #(.WORD_W(WORD_W)) u_pair (
    .word_a(word_a_r),
    .word_b(word_b_r),
    .big   (be_r),
    .value (rf_data)
  );

  assign ev_accept     = (state == ST_IDLE) && start;
  assign ev_word_lo    = (state == ST_WT_LO) && mem_valid;
  assign ev_word_hi    = (state == ST_WT_HI) && mem_valid;
  assign ev_last_write = (state == ST_WRITE) && (left_r == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_r   <= '0;
      wb_val_r <= '0;
      word_a_r <= '0;
      word_b_r <= '0;
      wb_idx_r <= '0;
      left_r   <= '0;
      idx_r    <= '0;
      be_r     <= 1'b0;
      wback_r  <= 1'b0;
      flags_r  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ev_accept) begin
            addr_r   <= f_first_addr(base_val, dec.offset, dec.up);
            wb_val_r <= f_wb_value(base_val, dec.offset, dec.up);
            wb_idx_r <= dec.rn;
            left_r   <= dec.count;
            idx_r    <= dec.first;
            be_r     <= big_endian;
            wback_r  <= dec.wback;
            flags_r  <= {dec.unhandled, dec.undef, dec.unpred};
            if (dec.unhandled || dec.undef) state <= ST_FIN;
            else if (dec.unpred)             state <= dec.nop_wb ? ST_WB : ST_FIN;
            else                             state <= ST_RQ_LO;
          end
        end
        ST_RQ_LO: state <= ST_WT_LO;
        ST_WT_LO: begin
          if (ev_word_lo) begin
            word_a_r <= mem_rdata;
            addr_r   <= addr_r + WORD_W'(WORD_BYTES);
            state    <= ST_RQ_HI;
          end
        end
        ST_RQ_HI: state <= ST_WT_HI;
        ST_WT_HI: begin
          if (ev_word_hi) begin
            word_b_r <= mem_rdata;
            addr_r   <= addr_r + WORD_W'(WORD_BYTES);
            state    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          left_r <= left_r - CNT_W'(1);
          idx_r  <= idx_r + IDX_W'(1);
          if (ev_last_write) state <= wback_r ? ST_WB : ST_FIN;
          else               state <= ST_RQ_LO;
        end
        ST_WB:   state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req        = (state == ST_RQ_LO) || (state == ST_RQ_HI);
  assign mem_addr       = addr_r;
  assign rf_we          = (state == ST_WRITE);
  assign rf_idx         = idx_r;
  assign wb_we          = (state == ST_WB);
  assign wb_idx         = wb_idx_r;
  assign wb_val         = wb_val_r;
  assign done           = (state == ST_FIN);
  assign unhandled_flag = done && flags_r[2];
  assign undef_flag     = done && flags_r[1];
  assign unpred_flag    = done && flags_r[0];

  // Handshake: a request never repeats in the next cycle (R8).
  assert_single_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // A register write follows a valid response (R8).
  assert_write_after_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(mem_valid));

  // Writeback is the last step before done (R7).
  assert_wb_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |=> done);

  // done lasts one cycle (R11).
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Flags only with done (R11).
  assert_flags_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_flag || unhandled_flag || unpred_flag) |-> done);

  // One outcome at a time (R2 priority).
  assert_flag_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({unhandled_flag, undef_flag, unpred_flag}));

  // No traffic while an outcome flag is pending (R9).
  assert_no_req_before_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_flag || unhandled_flag) |-> !$past(mem_req));

endmodule

// File: tb/dreg_load_seq_test.sv
module dreg_load_seq_test;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  idx;
    logic [63:0] data;
    logic [2:0]  flags;
  } item_t;

  localparam logic [1:0] K_RF = 2'd0, K_WB = 2'd1, K_DONE = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic        big_endian = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [63:0] rf_data;
  logic        wb_we;
  logic [3:0]  wb_idx;
  logic [31:0] wb_val;
  logic        done, undef_flag, unhandled_flag, unpred_flag;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int lat_sel = 1;
  int lat_cnt = 0;
  int cyc = 0;

  item_t       exp_q[$];
  logic [31:0] exp_addr[$];

  always #2 clk = ~clk;

  dreg_load_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base_val(base_val),
    .big_endian(big_endian), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_data(rf_data), .wb_we(wb_we), .wb_idx(wb_idx), .wb_val(wb_val), .done(done),
    .undef_flag(undef_flag), .unhandled_flag(unhandled_flag), .unpred_flag(unpred_flag)
  );

  function automatic logic [31:0] memw(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] mk(input bit p, input bit u, input bit w,
                                     input logic [4:0] d, input logic [3:0] rn,
                                     input logic [7:0] imm);
    return {4'hE, 3'b110, p, u, d[4], w, 1'b1, rn, d[3:0], 4'b1011, imm};
  endfunction

  task automatic check_item(input logic [1:0] kind, input logic [4:0] idx,
                            input logic [63:0] data, input logic [2:0] flags);
    item_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R12 unexpected event kind=%0d idx=%0d data=%h flags=%b, expected none",
               kind, idx, data, flags);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != kind || e.idx != idx || e.data != data || e.flags != flags) begin
      errors++;
      if (e.kind == K_RF)
        $display("FAIL R3 R6 write: got kind=%0d idx=%0d data=%h, expected idx=%0d data=%h",
                 kind, idx, data, e.idx, e.data);
      else if (e.kind == K_WB)
        $display("FAIL R7 writeback: got kind=%0d idx=%0d val=%h, expected idx=%0d val=%h",
                 kind, idx, data, e.idx, e.data);
      else
        $display("FAIL R1 R2 R9 R10 R11 done: got kind=%0d flags=%b, expected flags=%b",
                 kind, flags, e.flags);
    end
  endtask

  // Monitor: outputs are sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we) begin
        checks++;
        if (!mem_valid) begin
          errors++;
          $display("FAIL R8 write strobe without preceding valid: got 0, expected 1");
        end
        check_item(K_RF, rf_idx, rf_data, 3'b000);
      end
      if (wb_we) check_item(K_WB, {1'b0, wb_idx}, {32'h0, wb_val}, 3'b000);
      if (done) begin
        check_item(K_DONE, 5'd0, 64'd0, {unhandled_flag, undef_flag, unpred_flag});
        done_seen++;
      end
    end
  end

  // Memory model with a programmable response delay.
  always @(negedge clk) begin
    mem_valid <= 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= memw(mem_addr);
      end
    end
    if (rst_n && mem_req) begin
      checks++;
      if (lat_cnt != 0) begin
        errors++;
        $display("FAIL R8 request while read outstanding: got req=1, expected 0");
      end
      if (exp_addr.size() == 0) begin
        errors++;
        $display("FAIL R4 R5 R9 unexpected read at %h, expected none", mem_addr);
      end else begin
        logic [31:0] ea;
        ea = exp_addr.pop_front();
        if (ea != mem_addr) begin
          errors++;
          $display("FAIL R4 R5 read address: got %h, expected %h", mem_addr, ea);
        end
      end
      lat_cnt = lat_sel;
    end
  end

  // Driver: computes expectations from the requirements and starts the block.
  task automatic run_op(input logic [31:0] ins, input logic [31:0] base,
                        input logic be, input int lat, input bit poke);
    bit cls, p, u, w, unh, und, bad;
    int n, d, rn, target;
    logic [31:0] off, a, wbv;
    item_t it;
    cls = (ins[27:25] == 3'b110) && ins[20] && (ins[11:8] == 4'hB);
    p = ins[24]; u = ins[23]; w = ins[21];
    unh = !cls || (!p && !u && !w) || (p && !w);
    und = !unh && (p == u) && w;
    n   = int'(ins[7:1]);
    d   = int'({ins[22], ins[15:12]});
    rn  = int'(ins[19:16]);
    off = {22'd0, ins[7:0], 2'b00};
    wbv = u ? base + off : base - off;
    bad = (n > 16) || (d + n > 32) || (ins[0] && (d + n > 16)) || (rn == 15 && w);
    if (unh || und) begin
      it = '{K_DONE, 5'd0, 64'd0, {unh, und, 1'b0}};
      exp_q.push_back(it);
    end else if (n == 0 || bad) begin
      if (n == 0 && !bad && w) begin
        it = '{K_WB, 5'(rn), {32'h0, wbv}, 3'b000};
        exp_q.push_back(it);
      end
      it = '{K_DONE, 5'd0, 64'd0, 3'b001};
      exp_q.push_back(it);
    end else begin
      a = u ? base : base - off;
      for (int r = 0; r < n; r++) begin
        logic [31:0] w1, w2;
        exp_addr.push_back(a);
        exp_addr.push_back(a + 32'd4);
        w1 = memw(a);
        w2 = memw(a + 32'd4);
        it = '{K_RF, 5'(d + r), (be ? {w1, w2} : {w2, w1}), 3'b000};
        exp_q.push_back(it);
        a = a + 32'd8;
      end
      if (w) begin
        it = '{K_WB, 5'(rn), {32'h0, wbv}, 3'b000};
        exp_q.push_back(it);
      end
      it = '{K_DONE, 5'd0, 64'd0, 3'b000};
      exp_q.push_back(it);
    end
    target = done_seen + 1;
    @(negedge clk);
    instr = ins; base_val = base; big_endian = be; lat_sel = lat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R12: a second start mid-transfer, with a different order flag.
      repeat (3) @(negedge clk);
      instr = mk(0, 0, 1, 5'd1, 4'd2, 8'd3);
      big_endian = !be;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (done_seen >= target);
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || exp_addr.size() != 0) begin
      errors++;
      $display("FAIL R12 pending expectations: got %0d items %0d reads left, expected 0 0",
               exp_q.size(), exp_addr.size());
    end
    exp_q.delete();
    exp_addr.delete();
  endtask

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired: got %0d cycles, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (mem_req || rf_we || wb_we || done || undef_flag || unhandled_flag || unpred_flag) begin
      errors++;
      $display("FAIL R11 reset state: got outputs active, expected all low");
    end
    // R3 R4 R5 R6: increment, no writeback, little-endian.
    run_op(mk(0, 1, 0, 5'd2, 4'd1, 8'd7), 32'h0000_1000, 1'b0, 1, 0);
    // R6 R7: increment with writeback, big-endian.
    run_op(mk(0, 1, 1, 5'd0, 4'd3, 8'd9), 32'h0000_4000, 1'b1, 2, 0);
    // R4 R7: decrement before.
    run_op(mk(1, 0, 1, 5'd5, 4'd4, 8'd5), 32'h0000_2000, 1'b0, 3, 0);
    // R3: full list of 16 registers.
    run_op(mk(0, 1, 1, 5'd0, 4'd6, 8'd33), 32'h8000_0000, 1'b1, 1, 0);
    // R3: even immediate high in the index space.
    run_op(mk(0, 1, 0, 5'd20, 4'd2, 8'd16), 32'h0000_0100, 1'b0, 1, 0);
    // R2: undefined mode bits.
    run_op(mk(0, 0, 1, 5'd0, 4'd1, 8'd5), 32'h0, 1'b0, 1, 0);
    run_op(mk(1, 1, 1, 5'd0, 4'd1, 8'd5), 32'h0, 1'b0, 1, 0);
    // R1: other instructions.
    run_op(mk(0, 0, 0, 5'd0, 4'd1, 8'd5), 32'h0, 1'b0, 1, 0);
    run_op(mk(1, 0, 0, 5'd0, 4'd1, 8'd5), 32'h0, 1'b0, 1, 0);
    run_op(mk(0, 1, 1, 5'd0, 4'd1, 8'd5) & ~32'h0010_0000, 32'h0, 1'b0, 1, 0);
    run_op(mk(0, 1, 1, 5'd0, 4'd1, 8'd5) & ~32'h0000_0100, 32'h0, 1'b0, 1, 0);
    // R10: zero count with and without writeback.
    run_op(mk(1, 0, 1, 5'd3, 4'd7, 8'd1), 32'h0000_0500, 1'b0, 1, 0);
    run_op(mk(0, 1, 0, 5'd3, 4'd7, 8'd0), 32'h0000_0500, 1'b0, 1, 0);
    // R9: each unpredictable cause.
    run_op(mk(0, 1, 1, 5'd0, 4'd1, 8'd35), 32'h0, 1'b0, 1, 0);
    run_op(mk(0, 1, 0, 5'd10, 4'd1, 8'd15), 32'h0, 1'b0, 1, 0);
    run_op(mk(0, 1, 0, 5'd25, 4'd1, 8'd16), 32'h0, 1'b0, 1, 0);
    run_op(mk(0, 1, 1, 5'd0, 4'd15, 8'd3), 32'h0, 1'b0, 1, 0);
    // R9: base index 15 without writeback is legal.
    run_op(mk(0, 1, 0, 5'd1, 4'd15, 8'd3), 32'h0000_0800, 1'b1, 2, 0);
    // R12: start ignored mid-transfer.
    run_op(mk(0, 1, 1, 5'd8, 4'd9, 8'd9), 32'h0000_3000, 1'b1, 2, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule